// File: doc/BRIEF.md
# General-Purpose I/O Port Bank with Keyed Configuration Lock

This block gathers several 8-bit general-purpose I/O ports behind one small synchronous register bus. Every port owns a data register and a direction register. A direction bit of 1 drives the pin from the stored data bit; a direction bit of 0 releases the pin for input. Reading a data register always returns the level seen on the pins after a two-flop synchronizer, never the stored output value. Pins that a port does not implement (set by a per-port mask parameter) are never driven, and their bits read as zero.

A second group of registers holds pad configuration: a per-pin peripheral-select mask, a per-pin pull-up enable, a noise-filter enable byte and a drive-strength byte. Software can change these only while a lock register holds the key value 0x96. The lock register keeps whatever was last written to it, so the unlocked state lasts until software writes another value. When a pin's peripheral-select bit is set, that pin's output value and output enable come from the peripheral inputs, and the port's own data and direction bits no longer control it.

Top module: `gpio_bank`

## Requirements
- R1: Port p has its data register at address 2p and its direction register at 2p+1. All direction bits reset to 0, so no pin is driven after reset.
- R2: With a direction bit of 1 and the peripheral-select bit clear, `pin_oe` is high for that pin and `pin_out` equals the stored data bit, starting in the cycle after the write. A direction bit of 0 keeps `pin_oe` low.
- R3: A read of a data register returns `pin_in` as sampled through two flops. The value appears on `bus_rdata` two rising edges after the pin changes. It is never the stored output value, in either direction.
- R4: A write to a data register while the pin is an input stores the value without driving the pin. A later direction write of 1 drives the stored value.
- R5: Bits of the data and direction registers for pins outside the port's implemented mask always read 0, cannot be set, and never assert `pin_oe`.
- R6: Writes to the configuration registers take effect only while the lock register holds 0x96. These are peripheral select at 0x10+p, pull-up at 0x14+p, filter enable at 0x18 and drive strength at 0x19. With any other lock value the write is ignored. Reads of these registers work at any lock value.
- R7: The lock register at 0x1F reads back its stored value and changes only when written. While it holds 0x96, any number of configuration writes succeed.
- R8: Writes to the data and direction registers take effect at any lock value.
- R9: For a pin whose peripheral-select bit is 1, `pin_out` follows `periph_out` and `pin_oe` follows `periph_oe`.
- R10: Reads of unmapped addresses return 0. Writes to unmapped addresses change no register and no pin.
- R11: Reset clears the lock register and all configuration registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PORTS*8 | Pad input levels, port p at bits [8p+7:8p] |
| pin_out | output | NUM_PORTS*8 | Pad output values |
| pin_oe | output | NUM_PORTS*8 | Pad output enables |
| periph_out | input | NUM_PORTS*8 | Peripheral output values for selected pins |
| periph_oe | input | NUM_PORTS*8 | Peripheral output enables for selected pins |
| cfg_fsel | output | NUM_PORTS*8 | Peripheral-select mask per pin |
| cfg_pull | output | NUM_PORTS*8 | Pull-up enable per pin |
| cfg_filt | output | 8 | Noise-filter enable byte |
| cfg_drv | output | 8 | Drive-strength byte |

## Verification
The interesting overlap is a data-register write that lands in the same cycle as an edge on that port's input pins. The bench drives a new external level and a different data value at the same falling edge while the port is an input. Two edges later it expects the read to show the external level and the pins to stay undriven. It then switches the port to output and expects the written value on `pin_out`. A second overlap, a configuration write issued right after the lock is closed, is judged by reading the register back unchanged.

// File: rtl/gpio_bank_pkg.sv
// Package: address map and key shared by the port bank, its checker and bench.
// Assumes NUM_PORTS <= 4 so the per-port configuration windows do not overlap.
package gpio_bank_pkg;
    localparam int FSEL_BASE  = 'h10;
    localparam int PULL_BASE  = 'h14;
    localparam int FILT_ADDR  = 'h18;
    localparam int DRV_ADDR   = 'h19;
    localparam int LOCK_ADDR  = 'h1F;
    localparam logic [7:0] UNLOCK_KEY = 8'h96;
endpackage

// File: rtl/gpio_sync.sv
// Module: two-flop synchronizer for asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherency is promised.
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two stages of sampling, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_port.sv
// Module: one 8-bit port: data latch, direction register and pin muxing.
// Assumes write strobes are already decoded; IMPL marks implemented pins.
module gpio_port #(
    parameter logic [7:0] IMPL = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_data,
    input  logic       wr_dir,
    input  logic [7:0] wdata,
    input  logic [7:0] fsel,
    input  logic [7:0] periph_out,
    input  logic [7:0] periph_oe,
    input  logic [7:0] pin_sync,
    output logic [7:0] pin_out,
    output logic [7:0] pin_oe,
    output logic [7:0] rd_data,
    output logic [7:0] rd_dir
);
    logic [7:0] data_q;
    logic [7:0] dir_q;

    // Store data and direction, dropping unimplemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else begin
            if (wr_data) data_q <= wdata & IMPL;
            if (wr_dir)  dir_q  <= wdata & IMPL;
        end
    end

    // Select between port control and peripheral control per pin.
    always_comb begin
        pin_out = ((fsel & periph_out) | (~fsel & data_q)) & IMPL;
        pin_oe  = ((fsel & periph_oe)  | (~fsel & dir_q))  & IMPL;
    end

    assign rd_data = pin_sync & IMPL;
    assign rd_dir  = dir_q;
endmodule

// File: rtl/gpio_cfg_regs.sv
// Module: lock register plus the key-gated pad configuration registers.
// Assumes one bus write per cycle; reads are combinational and never gated.
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             wdata,
    output logic [7:0]             lock_q,
    output logic [NUM_PORTS*8-1:0] fsel,
    output logic [NUM_PORTS*8-1:0] pull,
    output logic [7:0]             filt,
    output logic [7:0]             drv,
    output logic [7:0]             rd_val
);
    logic open_w;
    assign open_w = (lock_q == UNLOCK_KEY);

    // Lock register: plain storage, never gated.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       lock_q <= '0;
        else if (we && addr == ADDR_W'(LOCK_ADDR))        lock_q <= wdata;
    end

    // Shared configuration bytes, written only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt <= '0;
            drv  <= '0;
        end else if (we && open_w) begin
            if (addr == ADDR_W'(FILT_ADDR)) filt <= wdata;
            if (addr == ADDR_W'(DRV_ADDR))  drv  <= wdata;
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_cfg
        // Per-port select and pull-up bytes, written only while unlocked.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fsel[p*8 +: 8] <= '0;
                pull[p*8 +: 8] <= '0;
            end else if (we && open_w) begin
                if (addr == ADDR_W'(FSEL_BASE + p)) fsel[p*8 +: 8] <= wdata;
                if (addr == ADDR_W'(PULL_BASE + p)) pull[p*8 +: 8] <= wdata;
            end
        end
    end

    // Readback of every configuration byte; zero when no address matches.
    always_comb begin
        rd_val = '0;
        if (addr == ADDR_W'(LOCK_ADDR)) rd_val = lock_q;
        if (addr == ADDR_W'(FILT_ADDR)) rd_val = filt;
        if (addr == ADDR_W'(DRV_ADDR))  rd_val = drv;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (addr == ADDR_W'(FSEL_BASE + p)) rd_val = fsel[p*8 +: 8];
            if (addr == ADDR_W'(PULL_BASE + p)) rd_val = pull[p*8 +: 8];
        end
    end
endmodule

// File: rtl/gpio_bank.sv
// Module: top of the port bank: bus decode, read mux, ports and config.
// Assumes a single-cycle write strobe and an address held for reads.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int                     NUM_PORTS = 4,
    parameter int                     ADDR_W    = 5,
    parameter logic [NUM_PORTS*8-1:0] IMPL_MASK = 32'h3FFF_0FFF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_we,
    input  logic [7:0]             bus_wdata,
    output logic [7:0]             bus_rdata,
    input  logic [NUM_PORTS*8-1:0] pin_in,
    output logic [NUM_PORTS*8-1:0] pin_out,
    output logic [NUM_PORTS*8-1:0] pin_oe,
    input  logic [NUM_PORTS*8-1:0] periph_out,
    input  logic [NUM_PORTS*8-1:0] periph_oe,
    output logic [NUM_PORTS*8-1:0] cfg_fsel,
    output logic [NUM_PORTS*8-1:0] cfg_pull,
    output logic [7:0]             cfg_filt,
    output logic [7:0]             cfg_drv
);
    localparam int PIN_W = NUM_PORTS * 8;

    logic [PIN_W-1:0]              pin_sync;
    logic [7:0]                    lock_q;
    logic [7:0]                    cfg_rd;
    logic [NUM_PORTS-1:0][7:0]     port_rd_data;
    logic [NUM_PORTS-1:0][7:0]     port_rd_dir;

    gpio_sync #(.W(PIN_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    gpio_cfg_regs #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .lock_q (lock_q),
        .fsel   (cfg_fsel),
        .pull   (cfg_pull),
        .filt   (cfg_filt),
        .drv    (cfg_drv),
        .rd_val (cfg_rd)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic wr_data_w;
        logic wr_dir_w;
        assign wr_data_w = bus_we && (bus_addr == ADDR_W'(2*p));
        assign wr_dir_w  = bus_we && (bus_addr == ADDR_W'(2*p + 1));

        gpio_port #(.IMPL(IMPL_MASK[p*8 +: 8])) u_port (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_data    (wr_data_w),
            .wr_dir     (wr_dir_w),
            .wdata      (bus_wdata),
            .fsel       (cfg_fsel[p*8 +: 8]),
            .periph_out (periph_out[p*8 +: 8]),
            .periph_oe  (periph_oe[p*8 +: 8]),
            .pin_sync   (pin_sync[p*8 +: 8]),
            .pin_out    (pin_out[p*8 +: 8]),
            .pin_oe     (pin_oe[p*8 +: 8]),
            .rd_data    (port_rd_data[p]),
            .rd_dir     (port_rd_dir[p])
        );
    end

    // Read mux: port registers first, configuration readback otherwise.
    always_comb begin
        bus_rdata = cfg_rd;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == ADDR_W'(2*p))     bus_rdata = port_rd_data[p];
            if (bus_addr == ADDR_W'(2*p + 1)) bus_rdata = port_rd_dir[p];
        end
    end
endmodule

// File: rtl/gpio_bank_chk.sv
// Module: property checker for the port bank, attached by bind.
// Assumes it sees the lock register value through the bind connection.
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int                     NUM_PORTS = 4,
    parameter int                     ADDR_W    = 5,
    parameter logic [NUM_PORTS*8-1:0] IMPL_MASK = 32'h3FFF_0FFF
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_we,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [7:0]             bus_rdata,
    input logic [NUM_PORTS*8-1:0] pin_oe,
    input logic [NUM_PORTS*8-1:0] cfg_fsel,
    input logic [NUM_PORTS*8-1:0] cfg_pull,
    input logic [7:0]             cfg_drv,
    input logic [7:0]             lock_q
);
    logic in_fsel, in_pull, mapped, lock_wr, locked;

    // Decode address classes independently of the design.
    always_comb begin
        int a;
        a       = int'(bus_addr);
        in_fsel = (a >= FSEL_BASE) && (a < FSEL_BASE + NUM_PORTS);
        in_pull = (a >= PULL_BASE) && (a < PULL_BASE + NUM_PORTS);
        mapped  = (a < 2*NUM_PORTS) || in_fsel || in_pull ||
                  (a == FILT_ADDR) || (a == DRV_ADDR) || (a == LOCK_ADDR);
        lock_wr = bus_we && (a == LOCK_ADDR);
        locked  = (lock_q != UNLOCK_KEY);
    end

    // R6
    fsel_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && in_fsel && locked) |=> $stable(cfg_fsel));

    // R6
    pull_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && in_pull && locked) |=> $stable(cfg_pull));

    // R6
    drv_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && int'(bus_addr) == DRV_ADDR && locked) |=> $stable(cfg_drv));

    // R5
    unimpl_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~IMPL_MASK) == '0);

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> bus_rdata == 8'h00);

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_wr |=> $stable(lock_q));

    // R11
    lock_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> lock_q == 8'h00);
endmodule

bind gpio_bank gpio_bank_chk #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W),
    .IMPL_MASK (IMPL_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .cfg_fsel  (cfg_fsel),
    .cfg_pull  (cfg_pull),
    .cfg_drv   (cfg_drv),
    .lock_q    (lock_q)
);

// File: tb/gpio_bank_tb.sv
// Directed bench for the port bank; each task checks its own scenario.
module gpio_bank_tb;
    localparam int NP = 4;
    localparam int AW = 5;
    localparam int PW = NP * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [PW-1:0] pin_in, pin_out, pin_oe;
    logic [PW-1:0] ext = '0;
    logic [PW-1:0] periph_out = '0;
    logic [PW-1:0] periph_oe = '0;
    logic [PW-1:0] cfg_fsel, cfg_pull;
    logic [7:0]    cfg_filt, cfg_drv;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    // Pad model: a driven pin shows its output, otherwise the external level.
    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

    gpio_bank u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .cfg_fsel   (cfg_fsel),
        .cfg_pull   (cfg_pull),
        .cfg_filt   (cfg_filt),
        .cfg_drv    (cfg_drv)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = AW'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        bus_addr = AW'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int p = 0; p < NP; p++) begin
            rd(2*p + 1, v);
            check("R1 dir reset", v, 8'h00);
        end
        check("R1 no pin driven", pin_oe, '0);
        rd('h1F, v);  check("R11 lock reset", v, 8'h00);
        rd('h10, v);  check("R11 fsel reset", v, 8'h00);
        check("R11 cfg outputs reset", {cfg_filt, cfg_drv}, 16'h0);
    endtask

    task automatic t_drive;
        logic [7:0] v;
        wr(0, 8'hA5);
        wr(1, 8'hFF);
        check("R2 out value", pin_out[7:0], 8'hA5);
        check("R2 oe all", pin_oe[7:0], 8'hFF);
        wr(1, 8'h0F);
        check("R2 oe partial", pin_oe[7:0], 8'h0F);
        rd(1, v);
        check("R1 dir readback", v, 8'h0F);
    endtask

    task automatic t_readback;
        logic [7:0] v;
        @(negedge clk);
        ext[23:16] = 8'h3C;
        @(negedge clk);
        rd(4, v);
        check("R3 one edge not yet", v, 8'h00);
        @(negedge clk);
        rd(4, v);
        check("R3 input level", v, 8'h3C);
        wr(4, 8'hFF);
        repeat (2) @(negedge clk);
        rd(4, v);
        check("R3 not latch", v, 8'h3C);
        rd(0, v);
        check("R3 output mode pin", v, 8'hA5 & 8'h0F | ext[7:0] & 8'hF0);
    endtask

    task automatic t_latch_input;
        wr(4, 8'h5A);
        check("R4 input undriven", pin_oe[23:16], 8'h00);
        wr(5, 8'hFF);
        check("R4 latched value out", pin_out[23:16], 8'h5A);
        check("R4 now driven", pin_oe[23:16], 8'hFF);
        wr(5, 8'h00);
    endtask

    task automatic t_unimpl;
        logic [7:0] v;
        @(negedge clk);
        ext[15:8] = 8'hF0;
        wr(3, 8'hFF);
        wr(2, 8'hFF);
        rd(3, v);
        check("R5 dir masked", v, 8'h0F);
        check("R5 oe masked", pin_oe[15:8], 8'h0F);
        repeat (2) @(negedge clk);
        rd(2, v);
        check("R5 data masked", v, 8'h0F);
    endtask

    task automatic t_protect;
        logic [7:0] v;
        wr('h10, 8'hFF);
        rd('h10, v);  check("R6 fsel locked", v, 8'h00);
        wr('h16, 8'hFF);
        rd('h16, v);  check("R6 pull locked", v, 8'h00);
        wr('h18, 8'hFF);
        check("R6 filt locked", cfg_filt, 8'h00);
        wr('h1F, 8'h96);
        rd('h1F, v);  check("R7 lock readback", v, 8'h96);
        wr('h11, 8'h03);
        wr('h16, 8'h77);
        wr('h19, 8'h05);
        wr('h18, 8'h03);
        rd('h11, v);  check("R7 fsel unlocked", v, 8'h03);
        rd('h16, v);  check("R7 pull unlocked", v, 8'h77);
        check("R7 drv unlocked", cfg_drv, 8'h05);
        check("R7 filt unlocked", cfg_filt, 8'h03);
        wr('h1F, 8'h69);
        wr('h19, 8'hAA);
        rd('h19, v);  check("R6 drv relocked", v, 8'h05);
        rd('h1F, v);  check("R7 lock holds", v, 8'h69);
    endtask

    task automatic t_unprotected;
        logic [7:0] v;
        wr(7, 8'hFF);
        rd(7, v);
        check("R8 dir while locked", v, 8'h3F);
        wr(6, 8'h21);
        check("R8 data while locked", pin_out[31:24], 8'h21);
    endtask

    task automatic t_periph;
        @(negedge clk);
        periph_out[7:0] = 8'h0A;
        periph_oe[7:0]  = 8'h03;
        wr('h1F, 8'h96);
        wr('h10, 8'h0F);
        wr('h1F, 8'h00);
        check("R9 periph oe", pin_oe[7:0], 8'h03);
        check("R9 periph out", pin_out[7:0], 8'hAA);
    endtask

    task automatic t_unmapped;
        logic [7:0]    v;
        logic [PW-1:0] oe_before;
        oe_before = pin_oe;
        wr('h0C, 8'hFF);
        rd('h0C, v);  check("R10 unmapped read", v, 8'h00);
        rd('h1B, v);  check("R10 unmapped high", v, 8'h00);
        check("R10 write no effect", pin_oe, oe_before);
    endtask

    task automatic t_same_cycle;
        logic [7:0] v;
        @(negedge clk);
        ext[23:16] = 8'h11;
        bus_addr   = AW'(4);
        bus_wdata  = 8'hEE;
        bus_we     = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        check("R4 same cycle undriven", pin_oe[23:16], 8'h00);
        @(negedge clk);
        rd(4, v);
        check("R3 same cycle pin", v, 8'h11);
        wr(5, 8'hFF);
        check("R4 same cycle latch", pin_out[23:16], 8'hEE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_drive();
        t_readback();
        t_latch_input();
        t_unimpl();
        t_protect();
        t_unprotected();
        t_periph();
        t_unmapped();
        t_same_cycle();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule